// File: doc/BRIEF.md
# Fast GPIO Port Register Block

This block is a 32-pin general-purpose I/O port controlled through a small memory-mapped register bank. Software programs a direction word, an access mask, an output latch and two write-one strobe registers (one raises bits, one lowers them). It reads back either the latch or the synchronized pin levels. Every register view can be reached as a full word, as either half-word or as any single byte. The bus lane strobes choose which bytes take part, in little-endian order.

The output latch feeds the pads directly. A pad's output enable is asserted only when its direction bit selects output and the pad is currently assigned to the GPIO function. A per-bit mask guards the latch and the input path. A masked bit cannot be changed through the pin, raise or lower registers, and it reads as zero through the pin and raise views. Pad inputs pass through a two-flop synchronizer before software sees them.

Top module: `gpio_fast_port`

## Requirements
- R1: Writing word index 6 (byte offset 0x18, the raise register) sets each latch bit whose write-data bit is 1. Bits written with 0 keep their value.
- R2: A raise write leaves unchanged every latch bit whose direction bit is 0 (input) or whose `gpio_sel` bit is 0 (pad given to another function).
- R3: Writing word index 7 (byte offset 0x1C, the lower register) clears each latch bit written with 1, under the same direction and function gating as R1/R2. This register reads as zero.
- R4: Writing word index 5 (byte offset 0x14, the pin register) loads the latch directly for every enabled, unmasked bit, regardless of direction.
- R5: With mask bit n at 1 (word index 4, byte offset 0x10), writes through the pin, raise and lower registers leave latch bit n unchanged. Reads of the pin and raise registers return 0 in bit n.
- R6: Reading the raise register returns the output latch (masked per R5), not the level on the pads.
- R7: Reading the pin register returns the pad inputs after a two-flop synchronizer. A pad change shows on the bus two rising edges after it is applied, and not after one.
- R8: `bus_be[k]` enables data bits 8k+7..8k for both reads and writes. A write changes no bit outside the enabled lanes, and a read returns 0 in lanes that are not enabled. Half-words use strobes 4'b0011 (pins 0-15) and 4'b1100 (pins 16-31).
- R9: Word index 0 (byte offset 0x00) is the direction register (1 = output) and reads back as written. Word indices 1, 2 and 3 read as zero, and writes to them change no state.
- R10: `pin_oe` equals direction AND `gpio_sel` bit by bit, and `pin_out` equals the output latch.
- R11: Synchronous reset clears the direction, mask and output latch to zero, which makes every pad an input driving low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 3 | Word index (byte offset divided by 4) |
| bus_be | input | 4 | Byte-lane enables, lane k = bits 8k+7..8k |
| bus_wdata | input | 32 | Write data, lane aligned |
| bus_rdata | output | 32 | Combinational read data |
| gpio_sel | input | 32 | Per-pad flag: pad is owned by GPIO |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Pad output levels (output latch) |
| pin_oe | output | 32 | Pad output enables |

## Verification
A latch bit that is corrupted internally shows on `pin_out` at the next clock edge. It also shows through the raise-register read in that same cycle, because the read path is combinational. A wrong direction or mask bit may stay hidden until a strobe write or pin read touches that pad. The vectors therefore pair each write with a readback in the next access, and they cross masked, input-direction, foreign-function and partial-lane bits. An error in the synchronizer depth shows only as an off-by-one latency, so that case is sampled after one edge and again after two.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int LANE_W   = 8;
    localparam int WADDR_W  = 3;

    // Word indices of the register views (byte offset / 4)
    localparam logic [WADDR_W-1:0] IDX_DIR  = 3'd0;
    localparam logic [WADDR_W-1:0] IDX_MASK = 3'd4;
    localparam logic [WADDR_W-1:0] IDX_PIN  = 3'd5;
    localparam logic [WADDR_W-1:0] IDX_SET  = 3'd6;
    localparam logic [WADDR_W-1:0] IDX_CLR  = 3'd7;

    typedef enum logic [2:0] {
        VIEW_NONE,
        VIEW_DIR,
        VIEW_MASK,
        VIEW_PIN,
        VIEW_SET,
        VIEW_CLR
    } view_e;

    typedef struct packed {
        logic wr_dir;
        logic wr_mask;
        logic wr_pin;
        logic wr_set;
        logic wr_clr;
    } wr_req_t;

    typedef struct packed {
        logic rd_dir;
        logic rd_mask;
        logic rd_pin;
        logic rd_set;
    } rd_req_t;

    function automatic view_e decode_view(input logic [WADDR_W-1:0] idx);
        view_e v;
        case (idx)
            IDX_DIR:  v = VIEW_DIR;
            IDX_MASK: v = VIEW_MASK;
            IDX_PIN:  v = VIEW_PIN;
            IDX_SET:  v = VIEW_SET;
            IDX_CLR:  v = VIEW_CLR;
            default:  v = VIEW_NONE;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gpio_access_decode.sv
module gpio_access_decode
    import gpio_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [WADDR_W-1:0] bus_waddr,
    input  logic [LANES-1:0]   bus_be,
    output wr_req_t            wr_req,
    output rd_req_t            rd_req,
    output logic [DATA_W-1:0]  lane_bits
);

    view_e view;

    assign view = decode_view(bus_waddr);

    // Expand byte strobes into a per-bit lane mask
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_bits[k*LANE_W +: LANE_W] = {LANE_W{bus_be[k]}};
    end

    always_comb begin
        wr_req = '0;
        rd_req = '0;
        if (bus_sel && bus_wr) begin
            wr_req.wr_dir  = (view == VIEW_DIR);
            wr_req.wr_mask = (view == VIEW_MASK);
            wr_req.wr_pin  = (view == VIEW_PIN);
            wr_req.wr_set  = (view == VIEW_SET);
            wr_req.wr_clr  = (view == VIEW_CLR);
        end
        if (bus_sel && !bus_wr) begin
            rd_req.rd_dir  = (view == VIEW_DIR);
            rd_req.rd_mask = (view == VIEW_MASK);
            rd_req.rd_pin  = (view == VIEW_PIN);
            rd_req.rd_set  = (view == VIEW_SET);
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= '0;
                else     stage_q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr_req,
    input  logic [DATA_W-1:0] lane_bits,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] gpio_sel,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] latch_q
);

    logic [DATA_W-1:0] open_bits;
    logic [DATA_W-1:0] drive_bits;
    logic [DATA_W-1:0] strobe_bits;
    logic [DATA_W-1:0] dir_d, mask_d, latch_d;

    assign open_bits   = lane_bits & ~mask_q;
    assign drive_bits  = dir_q & gpio_sel;
    assign strobe_bits = wdata & open_bits & drive_bits;

    always_comb begin
        dir_d   = dir_q;
        mask_d  = mask_q;
        latch_d = latch_q;
        if (wr_req.wr_dir)  dir_d   = (dir_q  & ~lane_bits) | (wdata & lane_bits);
        if (wr_req.wr_mask) mask_d  = (mask_q & ~lane_bits) | (wdata & lane_bits);
        if (wr_req.wr_pin)  latch_d = (latch_q & ~open_bits) | (wdata & open_bits);
        if (wr_req.wr_set)  latch_d = latch_q | strobe_bits;
        if (wr_req.wr_clr)  latch_d = latch_q & ~strobe_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            mask_q  <= '0;
            latch_q <= '0;
        end else begin
            dir_q   <= dir_d;
            mask_q  <= mask_d;
            latch_q <= latch_d;
        end
    end

    AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (rst)
        wr_req.wr_set |=> (($past(latch_q) & ~latch_q) == '0)); // R1

    AST_SET_GATED_BY_DRIVE: assert property (@(posedge clk) disable iff (rst)
        wr_req.wr_set |=> (((latch_q ^ $past(latch_q)) & ~($past(dir_q) & $past(gpio_sel))) == '0)); // R2

    AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (rst)
        wr_req.wr_clr |=> ((latch_q & ~$past(latch_q)) == '0)); // R3

    AST_MASK_HOLDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (wr_req.wr_pin || wr_req.wr_set || wr_req.wr_clr)
        |=> (((latch_q ^ $past(latch_q)) & $past(mask_q)) == '0)); // R5

    AST_LANE_CONFINES_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_req != '0) |=> ((((latch_q ^ $past(latch_q)) | (dir_q ^ $past(dir_q))
                             | (mask_q ^ $past(mask_q))) & ~$past(lane_bits)) == '0)); // R8

    AST_IDLE_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        (wr_req == '0) |=> ($stable(dir_q) && $stable(mask_q) && $stable(latch_q))); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (dir_q == '0 && mask_q == '0 && latch_q == '0)); // R11

endmodule

// File: rtl/gpio_fast_port.sv
module gpio_fast_port
    import gpio_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2,
    localparam int LANES      = DATA_W / LANE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [WADDR_W-1:0] bus_waddr,
    input  logic [LANES-1:0]   bus_be,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0]  gpio_sel,
    input  logic [DATA_W-1:0]  pin_in,
    output logic [DATA_W-1:0]  pin_out,
    output logic [DATA_W-1:0]  pin_oe
);

    wr_req_t           wr_req;
    rd_req_t           rd_req;
    logic [DATA_W-1:0] lane_bits;
    logic [DATA_W-1:0] dir_q, mask_q, latch_q;
    logic [DATA_W-1:0] pin_sync;
    logic [DATA_W-1:0] view_word;

    gpio_access_decode #(.DATA_W(DATA_W)) u_decode (
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_be    (bus_be),
        .wr_req    (wr_req),
        .rd_req    (rd_req),
        .lane_bits (lane_bits)
    );

    gpio_port_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_req    (wr_req),
        .lane_bits (lane_bits),
        .wdata     (bus_wdata),
        .gpio_sel  (gpio_sel),
        .dir_q     (dir_q),
        .mask_q    (mask_q),
        .latch_q   (latch_q)
    );

    gpio_in_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pin_sync)
    );

    always_comb begin
        view_word = '0;
        unique case (1'b1)
            rd_req.rd_dir:  view_word = dir_q;
            rd_req.rd_mask: view_word = mask_q;
            rd_req.rd_pin:  view_word = pin_sync & ~mask_q;
            rd_req.rd_set:  view_word = latch_q & ~mask_q;
            default:        view_word = '0;
        endcase
    end

    assign bus_rdata = view_word & lane_bits;
    assign pin_out   = latch_q;
    assign pin_oe    = dir_q & gpio_sel;

    AST_MASKED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && (bus_waddr == IDX_PIN || bus_waddr == IDX_SET))
        |-> ((bus_rdata & mask_q) == '0)); // R5

    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_waddr == IDX_CLR) |-> (bus_rdata == '0)); // R3

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        AST_IDLE_LANE_ZERO: assert property (@(posedge clk) disable iff (rst)
            !bus_be[k] |-> (bus_rdata[k*LANE_W +: LANE_W] == '0)); // R8
    end

endmodule

// File: tb/gpio_fast_port_tb.sv
module gpio_fast_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 25;

    typedef struct packed {
        logic        wr;
        logic [2:0]  idx;
        logic [3:0]  be;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    // pin_in = A5A50F0F, gpio_sel = all ones during the table
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd0, 4'hF, 32'hFFFF0000, 32'h0},         // R9 direction upper half out
        '{1'b0, 3'd0, 4'hF, 32'h0, 32'hFFFF0000},         // R9 direction readback
        '{1'b1, 3'd6, 4'hF, 32'h12345678, 32'h0},         // R1 R2 raise, inputs ignored
        '{1'b0, 3'd6, 4'hF, 32'h0, 32'h12340000},         // R1 R2
        '{1'b1, 3'd7, 4'hF, 32'h00300000, 32'h0},         // R3 lower
        '{1'b0, 3'd6, 4'hF, 32'h0, 32'h12040000},         // R3
        '{1'b1, 3'd5, 4'hF, 32'h0000ABCD, 32'h0},         // R4 direct load, any direction
        '{1'b0, 3'd6, 4'hF, 32'h0, 32'h0000ABCD},         // R4 R6 latch not pads
        '{1'b0, 3'd5, 4'hF, 32'h0, 32'hA5A50F0F},         // R7 synced pads
        '{1'b1, 3'd4, 4'hF, 32'h000000FF, 32'h0},         // R5 mask low byte
        '{1'b0, 3'd5, 4'hF, 32'h0, 32'hA5A50F00},         // R5 masked pin read
        '{1'b0, 3'd6, 4'hF, 32'h0, 32'h0000AB00},         // R5 masked raise read
        '{1'b1, 3'd5, 4'hF, 32'hFFFFFFFF, 32'h0},         // R5 masked write
        '{1'b1, 3'd4, 4'hF, 32'h00000000, 32'h0},         // R5 unmask
        '{1'b0, 3'd6, 4'hF, 32'h0, 32'hFFFFFFCD},         // R5 masked bits held
        '{1'b1, 3'd7, 4'h4, 32'hFFFFFFFF, 32'h0},         // R8 byte-2 lower
        '{1'b0, 3'd6, 4'hF, 32'h0, 32'hFF00FFCD},         // R8
        '{1'b0, 3'd6, 4'hC, 32'h0, 32'hFF000000},         // R8 upper half read
        '{1'b0, 3'd5, 4'h1, 32'h0, 32'h0000000F},         // R8 byte-0 read
        '{1'b1, 3'd5, 4'h3, 32'h00001234, 32'h0},         // R8 lower half write
        '{1'b0, 3'd6, 4'hF, 32'h0, 32'hFF001234},         // R8
        '{1'b0, 3'd7, 4'hF, 32'h0, 32'h00000000},         // R3 R9 lower reads zero
        '{1'b0, 3'd2, 4'hF, 32'h0, 32'h00000000},         // R9 hole reads zero
        '{1'b1, 3'd1, 4'hF, 32'hFFFFFFFF, 32'h0},         // R9 hole write
        '{1'b0, 3'd0, 4'hF, 32'h0, 32'hFFFF0000}          // R9 hole write ignored
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] gpio_sel = '1;
    logic [31:0] pin_in = 32'hA5A50F0F;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_fast_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gpio_sel  (gpio_sel),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] idx, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = idx; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] idx, input logic [3:0] be,
                            input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = idx; bus_be = be;
        #1;
        check(tag, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        check("R11 pin_oe after reset", pin_oe, 32'h0);
        check("R11 pin_out after reset", pin_out, 32'h0);
        bus_read(3'd0, 4'hF, 32'h0, "R11 direction after reset");
        bus_read(3'd4, 4'hF, 32'h0, "R11 mask after reset");

        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].idx, VECS[i].be, VECS[i].data);
            else bus_read(VECS[i].idx, VECS[i].be, VECS[i].exp,
                          $sformatf("vector %0d (R1..R9 table)", i));
        end

        // R10 pad drive
        check("R10 pin_oe", pin_oe, 32'hFFFF0000);
        check("R10 pin_out", pin_out, 32'hFF001234);
        @(negedge clk);
        gpio_sel = 32'hF0F0F0F0;
        #1;
        check("R10 pin_oe follows gpio_sel", pin_oe, 32'hF0F00000);

        // R2 pads given to another function ignore raise
        bus_write(3'd6, 4'hF, 32'hFFFFFFFF);
        check("R2 raise with foreign pads", pin_out, 32'hFFF01234);
        bus_read(3'd6, 4'hF, 32'hFFF01234, "R2 R6 raise readback");

        // R7 two-edge latency
        @(negedge clk);
        pin_in = 32'h12345678;
        bus_read(3'd5, 4'hF, 32'hA5A50F0F, "R7 after one edge");
        bus_read(3'd5, 4'hF, 32'h12345678, "R7 after two edges");

        // R11 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11 pin_out cleared", pin_out, 32'h0);
        check("R11 pin_oe cleared", pin_oe, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule